// File: doc/BRIEF.md
# Two-Way Data Cache Array with Test Access

This block holds the storage of a small two-way set-associative data cache and makes every bit of it reachable through a register-level test port. There are 128 sets per way, and each line is made of eight 32-bit words. Each line also has a 24-bit tag, a two-bit coherence state and a writeback/writethrough attribute. Each set has one replacement pointer that names a way. A host loads a 32-bit data holding register and a tag holding register. It then writes a command word that names a way, a set, a word of the line and an operation. The operations are test write, test read, flush and a no-op.

A test write copies both holding registers into the addressed location in one clock. A test read copies the location back into the holding registers and marks completion with a one-cycle pulse. A flush walks all sets, one set per clock, and marks every line of both ways invalid. A busy flag stays high for the whole walk, and the block accepts no command while it is high. A separate combinational lookup port compares a presented tag against both ways of a set. It reports a hit, the way that hit and that line's writeback attribute. Refill from the bus and replacement updates are not part of the block.

Top module: `dcache_test_port`

## Requirements
- R1: After reset, `busy`, `done`, `dat_q` and `tag_q` are all zero and every line is Invalid, so no lookup hits.
- R2: The command word is decoded as: operation in bits 1..0, word index in bits 4..2, set in bits 11..5, way in bit 12, writeback attribute in bit 14. Operation 00 is a no-op: it changes neither the array nor the holding registers, and it raises no `done`.
- R3: Operation 01 (test write) stores the data holding register into the addressed word. It stores the tag field and the state into the addressed way's tag entry, the replacement bit into the set's pointer, and command bit 14 into the line's writeback attribute (1 writeback, 0 writethrough). All of this happens on the clock edge that accepts the command.
- R4: Operation 10 (test read) loads `dat_q` from the addressed word and `tag_q` from the addressed way's tag and state and the set's pointer, on the accepting edge. `done` is high for exactly the cycle after that edge.
- R5: The tag holding register uses bits 31..8 for the tag, bit 2 for the replacement pointer (1 means way 1) and bits 1..0 for the state. Bits 7..3 always read back as zero.
- R6: Operation 11 (flush) raises `busy` on the accepting edge and holds it for exactly 128 cycles. When it falls, every line of both ways is Invalid, while the tags, the data words and the replacement pointers are unchanged.
- R7: A command presented while `busy` is high is ignored: no array write takes place and no `done` is raised.
- R8: The lookup reports `hit` only when `lk_valid` is high, a way's stored tag equals `lk_tag` and that line's state is not Invalid. On a hit it gives that way on `hit_way` and its attribute on `hit_wb`. Without a hit both are zero.
- R9: When both ways of the set match, way 0 is reported.
- R10: The state codes are 11 Modified, 10 Exclusive, 01 Shared and 00 Invalid. Every code other than 00 counts as valid for a lookup.
- R11: `dat_we` and `tag_we` load the holding registers from the host, and a write is visible on `dat_q`/`tag_q` after the edge. When a test read is accepted on the same edge, the read result wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Command strobe for `ctl_word` |
| ctl_word | input | 32 | Command word: operation, word index, set, way, writeback attribute |
| dat_we | input | 1 | Load data holding register from host |
| dat_wdata | input | 32 | Host value for data holding register |
| tag_we | input | 1 | Load tag holding register from host |
| tag_wdata | input | 32 | Host value for tag holding register |
| dat_q | output | 32 | Data holding register contents |
| tag_q | output | 32 | Tag holding register contents |
| done | output | 1 | One-cycle completion pulse of a test read |
| busy | output | 1 | Flush in progress |
| lk_valid | input | 1 | Lookup request valid |
| lk_set | input | 7 | Lookup set index |
| lk_tag | input | 24 | Lookup tag |
| hit | output | 1 | Lookup hit |
| hit_way | output | 1 | Way that hit |
| hit_wb | output | 1 | Writeback attribute of the line that hit |

## Verification
The assertions check several rules on every cycle. `busy` never lasts more than 128 cycles, and it can only rise after an accepted flush. Every `done` traces back to an accepted test read, and a command seen while busy never produces `done`. The reserved tag bits stay zero. No hit appears without a valid request, and a miss always drives zeros on `hit_way` and `hit_wb`. The bench scenarios cover what a single cycle cannot show. They check that written words and tags return through later reads at the exact field positions, including the set and word boundaries. They check that a flush leaves tags, data and pointers intact while invalidating every state, that commands ignored during a flush leave the array untouched, and that a read beats a host write of the same register.

// File: rtl/dctp_pkg.sv
`timescale 1ns/1ps
package dctp_pkg;

    localparam int unsigned NUM_WAYS     = 2;
    localparam int unsigned NUM_SETS     = 128;
    localparam int unsigned NUM_PORTIONS = 8;
    localparam int unsigned WORD_W       = 32;
    localparam int unsigned TAG_W        = 24;

    localparam int unsigned WAY_W = $clog2(NUM_WAYS);
    localparam int unsigned SET_W = $clog2(NUM_SETS);
    localparam int unsigned POR_W = $clog2(NUM_PORTIONS);

    // Command word field positions (decoded by this block)
    localparam int unsigned CW_OP_LSB  = 0;
    localparam int unsigned CW_POR_LSB = 2;
    localparam int unsigned CW_SET_LSB = 5;
    localparam int unsigned CW_WAY_LSB = 12;
    localparam int unsigned CW_WB_BIT  = 14;

    // Tag holding register field positions
    localparam int unsigned TW_ST_LSB  = 0;
    localparam int unsigned TW_LRU_BIT = 2;
    localparam int unsigned TW_TAG_LSB = WORD_W - TAG_W;

    typedef enum logic [1:0] {
        OP_NORMAL = 2'b00,
        OP_TWRITE = 2'b01,
        OP_TREAD  = 2'b10,
        OP_FLUSH  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_EXC = 2'b10,
        LS_MOD = 2'b11
    } lstate_e;

    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [SET_W-1:0]  set_t;
    typedef logic [POR_W-1:0]  por_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef struct packed {
        logic wb;
        way_t way;
        set_t set;
        por_t por;
        op_e  op;
    } cmd_t;

    typedef struct packed {
        tag_t    tag;
        logic    lru;
        lstate_e st;
    } tagrec_t;

    function automatic cmd_t decode_cmd(input word_t w);
        cmd_t c;
        c.wb  = w[CW_WB_BIT];
        c.way = w[CW_WAY_LSB +: WAY_W];
        c.set = w[CW_SET_LSB +: SET_W];
        c.por = w[CW_POR_LSB +: POR_W];
        c.op  = op_e'(w[CW_OP_LSB +: 2]);
        return c;
    endfunction

    function automatic tagrec_t unpack_tag(input word_t w);
        tagrec_t r;
        r.tag = w[TW_TAG_LSB +: TAG_W];
        r.lru = w[TW_LRU_BIT];
        r.st  = lstate_e'(w[TW_ST_LSB +: 2]);
        return r;
    endfunction

    function automatic word_t pack_tag(input tagrec_t r);
        word_t w;
        w = '0;
        w[TW_TAG_LSB +: TAG_W] = r.tag;
        w[TW_LRU_BIT]          = r.lru;
        w[TW_ST_LSB +: 2]      = r.st;
        return w;
    endfunction

endpackage

// File: rtl/dctp_ctrl.sv
`timescale 1ns/1ps
module dctp_ctrl
    import dctp_pkg::*;
#(
    parameter int unsigned SETS = NUM_SETS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_we,
    input  op_e                      op,
    output logic                     wr_go,
    output logic                     rd_go,
    output logic                     clr_en,
    output logic [$clog2(SETS)-1:0]  clr_set,
    output logic                     busy,
    output logic                     done
);

    localparam int unsigned CNT_W = $clog2(SETS);
    localparam logic [CNT_W-1:0] LAST_SET = CNT_W'(SETS - 1);

    typedef enum logic {PH_IDLE, PH_FLUSH} phase_e;

    phase_e           phase;
    logic [CNT_W-1:0] walk;
    logic             accept;
    logic             fl_go;

    assign accept = cmd_we && (phase == PH_IDLE);
    assign wr_go  = accept && (op == OP_TWRITE);
    assign rd_go  = accept && (op == OP_TREAD);
    assign fl_go  = accept && (op == OP_FLUSH);

    assign busy    = (phase == PH_FLUSH);
    assign clr_en  = busy;
    assign clr_set = walk;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            walk  <= '0;
            done  <= 1'b0;
        end else begin
            done <= rd_go;
            case (phase)
                PH_IDLE: begin
                    if (fl_go) begin
                        phase <= PH_FLUSH;
                        walk  <= '0;
                    end
                end
                PH_FLUSH: begin
                    if (walk == LAST_SET) begin
                        phase <= PH_IDLE;
                    end
                    walk <= walk + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dctp_data_array.sv
`timescale 1ns/1ps
module dctp_data_array
    import dctp_pkg::*;
#(
    parameter int unsigned WAYS     = NUM_WAYS,
    parameter int unsigned SETS     = NUM_SETS,
    parameter int unsigned PORTIONS = NUM_PORTIONS,
    parameter int unsigned W        = WORD_W
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [$clog2(WAYS)-1:0]     way,
    input  logic [$clog2(SETS)-1:0]     set,
    input  logic [$clog2(PORTIONS)-1:0] por,
    input  logic [W-1:0]                wr_data,
    output logic [W-1:0]                rd_data
);

    localparam int unsigned WAY_BITS = $clog2(WAYS);
    localparam int unsigned DEPTH    = SETS * PORTIONS;
    localparam int unsigned ADDR_W   = $clog2(DEPTH);

    logic [ADDR_W-1:0] addr;
    logic [W-1:0]      rd_w [WAYS];

    assign addr = {set, por};

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [W-1:0] mem [DEPTH];
        logic         sel;

        assign sel = wr_en && (way == WAY_BITS'(g));

        always_ff @(posedge clk) begin
            if (sel) begin
                mem[addr] <= wr_data;
            end
        end

        assign rd_w[g] = mem[addr];
    end

    assign rd_data = rd_w[way];

endmodule

// File: rtl/dctp_tag_array.sv
`timescale 1ns/1ps
module dctp_tag_array
    import dctp_pkg::*;
#(
    parameter int unsigned WAYS = NUM_WAYS,
    parameter int unsigned SETS = NUM_SETS
) (
    input  logic                            clk,
    input  logic                            rst,
    // test write
    input  logic                            wr_en,
    input  logic [$clog2(WAYS)-1:0]         wr_way,
    input  logic [$clog2(SETS)-1:0]         wr_set,
    input  tagrec_t                         wr_rec,
    input  logic                            wr_wb,
    // test read
    input  logic [$clog2(WAYS)-1:0]         rd_way,
    input  logic [$clog2(SETS)-1:0]         rd_set,
    output tagrec_t                         rd_rec,
    // flush
    input  logic                            clr_en,
    input  logic [$clog2(SETS)-1:0]         clr_set,
    // lookup
    input  logic [$clog2(SETS)-1:0]         lk_set,
    output logic [WAYS-1:0][TAG_W-1:0]      lk_tag,
    output logic [WAYS-1:0][1:0]            lk_st,
    output logic [WAYS-1:0]                 lk_wb
);

    localparam int unsigned WAY_BITS = $clog2(WAYS);

    logic                          lru_mem [SETS];
    logic [WAYS-1:0][TAG_W-1:0]    rd_tag_w;
    logic [WAYS-1:0][1:0]          rd_st_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                lru_mem[s] <= 1'b0;
            end
        end else if (wr_en) begin
            lru_mem[wr_set] <= wr_rec.lru;
        end
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        tag_t    tag_mem [SETS];
        lstate_e st_mem  [SETS];
        logic    wb_mem  [SETS];
        logic    sel;

        assign sel = wr_en && (wr_way == WAY_BITS'(g));

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_mem[wr_set] <= wr_rec.tag;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++) begin
                    st_mem[s] <= LS_INV;
                    wb_mem[s] <= 1'b0;
                end
            end else if (clr_en) begin
                st_mem[clr_set] <= LS_INV;
            end else if (sel) begin
                st_mem[wr_set] <= wr_rec.st;
                wb_mem[wr_set] <= wr_wb;
            end
        end

        assign rd_tag_w[g] = tag_mem[rd_set];
        assign rd_st_w[g]  = st_mem[rd_set];
        assign lk_tag[g]   = tag_mem[lk_set];
        assign lk_st[g]    = st_mem[lk_set];
        assign lk_wb[g]    = wb_mem[lk_set];
    end

    always_comb begin
        rd_rec.tag = rd_tag_w[rd_way];
        rd_rec.lru = lru_mem[rd_set];
        rd_rec.st  = lstate_e'(rd_st_w[rd_way]);
    end

endmodule

// File: rtl/dctp_lookup.sv
`timescale 1ns/1ps
module dctp_lookup
    import dctp_pkg::*;
#(
    parameter int unsigned WAYS = NUM_WAYS
) (
    input  logic                        lk_valid,
    input  tag_t                        lk_tag,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [WAYS-1:0][1:0]        way_st,
    input  logic [WAYS-1:0]             way_wb,
    output logic                        hit,
    output logic [$clog2(WAYS)-1:0]     hit_way,
    output logic                        hit_wb
);

    localparam int unsigned WAY_BITS = $clog2(WAYS);

    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = lk_valid && (way_tag[g] == lk_tag) && (way_st[g] != LS_INV);
    end

    // Lowest-numbered matching way wins.
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        hit_wb  = 1'b0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_way = WAY_BITS'(i);
                hit_wb  = way_wb[i];
            end
        end
    end

endmodule

// File: rtl/dcache_test_port.sv
`timescale 1ns/1ps
module dcache_test_port
    import dctp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [WORD_W-1:0] ctl_word,
    input  logic              dat_we,
    input  logic [WORD_W-1:0] dat_wdata,
    input  logic              tag_we,
    input  logic [WORD_W-1:0] tag_wdata,
    output logic [WORD_W-1:0] dat_q,
    output logic [WORD_W-1:0] tag_q,
    output logic              done,
    output logic              busy,
    input  logic              lk_valid,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic              hit_wb
);

    cmd_t    cmd;
    word_t   dat_reg;
    tagrec_t tag_reg;
    word_t   arr_word;
    tagrec_t arr_rec;

    logic    wr_go;
    logic    rd_go;
    logic    clr_en;
    set_t    clr_set;

    logic [NUM_WAYS-1:0][TAG_W-1:0] way_tag;
    logic [NUM_WAYS-1:0][1:0]       way_st;
    logic [NUM_WAYS-1:0]            way_wb;

    logic unused_bits;
    assign unused_bits = ^{ctl_word[WORD_W-1:CW_WB_BIT+1], ctl_word[CW_WB_BIT-1:CW_WAY_LSB+WAY_W],
                           tag_wdata[TW_TAG_LSB-1:TW_LRU_BIT+1]};

    assign cmd = decode_cmd(ctl_word);

    dctp_ctrl #(
        .SETS (NUM_SETS)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cmd_we  (ctl_we),
        .op      (cmd.op),
        .wr_go   (wr_go),
        .rd_go   (rd_go),
        .clr_en  (clr_en),
        .clr_set (clr_set),
        .busy    (busy),
        .done    (done)
    );

    dctp_data_array #(
        .WAYS     (NUM_WAYS),
        .SETS     (NUM_SETS),
        .PORTIONS (NUM_PORTIONS),
        .W        (WORD_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (wr_go),
        .way     (cmd.way),
        .set     (cmd.set),
        .por     (cmd.por),
        .wr_data (dat_reg),
        .rd_data (arr_word)
    );

    dctp_tag_array #(
        .WAYS (NUM_WAYS),
        .SETS (NUM_SETS)
    ) u_tags (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_go),
        .wr_way  (cmd.way),
        .wr_set  (cmd.set),
        .wr_rec  (tag_reg),
        .wr_wb   (cmd.wb),
        .rd_way  (cmd.way),
        .rd_set  (cmd.set),
        .rd_rec  (arr_rec),
        .clr_en  (clr_en),
        .clr_set (clr_set),
        .lk_set  (lk_set),
        .lk_tag  (way_tag),
        .lk_st   (way_st),
        .lk_wb   (way_wb)
    );

    dctp_lookup #(
        .WAYS (NUM_WAYS)
    ) u_lookup (
        .lk_valid (lk_valid),
        .lk_tag   (lk_tag),
        .way_tag  (way_tag),
        .way_st   (way_st),
        .way_wb   (way_wb),
        .hit      (hit),
        .hit_way  (hit_way),
        .hit_wb   (hit_wb)
    );

    // Holding registers: an accepted test read takes priority over host loads.
    always_ff @(posedge clk) begin
        if (rst) begin
            dat_reg <= '0;
            tag_reg <= '0;
        end else if (rd_go) begin
            dat_reg <= arr_word;
            tag_reg <= arr_rec;
        end else begin
            if (dat_we) begin
                dat_reg <= dat_wdata;
            end
            if (tag_we) begin
                tag_reg <= unpack_tag(tag_wdata);
            end
        end
    end

    assign dat_q = dat_reg;
    assign tag_q = pack_tag(tag_reg);

endmodule

// File: rtl/dctp_checker.sv
`timescale 1ns/1ps
module dctp_checker
    import dctp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ctl_we,
    input logic [1:0]       ctl_op,
    input logic             busy,
    input logic             done,
    input logic             lk_valid,
    input logic             hit,
    input logic [WAY_W-1:0] hit_way,
    input logic             hit_wb,
    input logic [4:0]       tag_resv
);

    localparam int unsigned RUN_W = $clog2(NUM_SETS) + 2;

    logic [RUN_W-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + 1'b1;
        end else begin
            busy_run <= '0;
        end
    end

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_run <= RUN_W'(NUM_SETS));                                              // R6

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ctl_we && ctl_op == 2'b11));                          // R6

    AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(ctl_we && ctl_op == 2'b10 && !busy));                       // R4

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (busy && ctl_we) |=> !done);                                                // R7

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        hit |-> lk_valid);                                                          // R8

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_way == '0 && !hit_wb));                                       // R8

    AST_TAG_RESV_ZERO: assert property (@(posedge clk) disable iff (rst)
        tag_resv == 5'b0);                                                          // R5

endmodule

bind dcache_test_port dctp_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctl_we   (ctl_we),
    .ctl_op   (ctl_word[1:0]),
    .busy     (busy),
    .done     (done),
    .lk_valid (lk_valid),
    .hit      (hit),
    .hit_way  (hit_way),
    .hit_wb   (hit_wb),
    .tag_resv (tag_q[7:3])
);

// File: tb/tb_dcache_test_port.sv
`timescale 1ns/1ps
module tb_dcache_test_port;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_we;
    logic [31:0] ctl_word;
    logic        dat_we;
    logic [31:0] dat_wdata;
    logic        tag_we;
    logic [31:0] tag_wdata;
    logic [31:0] dat_q;
    logic [31:0] tag_q;
    logic        done;
    logic        busy;
    logic        lk_valid;
    logic [6:0]  lk_set;
    logic [23:0] lk_tag;
    logic        hit;
    logic        hit_way;
    logic        hit_wb;

    int n_chk = 0;
    int n_err = 0;
    int busy_cycles = 0;

    localparam logic [31:0] WA = 32'hA5A5_0003;
    localparam logic [31:0] WB = 32'h5A5A_0004;
    localparam logic [31:0] WC = 32'hC0DE_7F07;
    localparam logic [31:0] WD = 32'h0BAD_F00D;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (busy) busy_cycles++;
    end

    dcache_test_port dut (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_word  (ctl_word),
        .dat_we    (dat_we),
        .dat_wdata (dat_wdata),
        .tag_we    (tag_we),
        .tag_wdata (tag_wdata),
        .dat_q     (dat_q),
        .tag_q     (tag_q),
        .done      (done),
        .busy      (busy),
        .lk_valid  (lk_valid),
        .lk_set    (lk_set),
        .lk_tag    (lk_tag),
        .hit       (hit),
        .hit_way   (hit_way),
        .hit_wb    (hit_wb)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input logic wb, input logic way, input logic [6:0] s,
                                       input logic [2:0] p, input logic [1:0] op);
        return {17'b0, wb, 1'b0, way, s, p, op};
    endfunction

    function automatic logic [31:0] tw(input logic [23:0] t, input logic lru, input logic [1:0] st);
        return {t, 5'b0, lru, st};
    endfunction

    task automatic load_regs(input logic [31:0] d, input logic [31:0] t);
        dat_we = 1'b1; dat_wdata = d;
        tag_we = 1'b1; tag_wdata = t;
        step();
        dat_we = 1'b0; tag_we = 1'b0;
    endtask

    task automatic issue(input logic [31:0] w);
        ctl_we = 1'b1; ctl_word = w;
        step();
        ctl_we = 1'b0;
    endtask

    task automatic twrite(input logic wb, input logic way, input logic [6:0] s, input logic [2:0] p,
                          input logic [31:0] d, input logic [31:0] t);
        load_regs(d, t);
        issue(cw(wb, way, s, p, 2'b01));
    endtask

    task automatic tread(input logic way, input logic [6:0] s, input logic [2:0] p);
        issue(cw(1'b0, way, s, p, 2'b10));
    endtask

    task automatic look(input logic v, input logic [6:0] s, input logic [23:0] t);
        lk_valid = v; lk_set = s; lk_tag = t;
        #0.2;
    endtask

    task automatic test_reset();
        check("R1", "busy", {31'b0, busy}, 32'd0);
        check("R1", "done", {31'b0, done}, 32'd0);
        check("R1", "dat_q", dat_q, 32'd0);
        check("R1", "tag_q", tag_q, 32'd0);
        look(1'b1, 7'd5, 24'd0);
        check("R1", "hit after reset", {31'b0, hit}, 32'd0);
    endtask

    task automatic test_host_regs();
        load_regs(32'hDEAD_BEEF, 32'hFFFF_FFFF);
        check("R11", "dat_q host load", dat_q, 32'hDEAD_BEEF);
        check("R5", "tag_q reserved bits", tag_q, 32'hFFFF_FF07);
    endtask

    task automatic test_write_read();
        twrite(1'b1, 1'b1, 7'd5, 3'd3, WA, tw(24'hABCDE1, 1'b1, 2'b11));
        twrite(1'b1, 1'b1, 7'd5, 3'd4, WB, tw(24'hABCDE1, 1'b1, 2'b11));
        load_regs(32'd0, 32'd0);
        tread(1'b1, 7'd5, 3'd3);
        check("R4", "done after read", {31'b0, done}, 32'd1);
        check("R3", "data word 3", dat_q, WA);
        check("R3", "tag record", tag_q, tw(24'hABCDE1, 1'b1, 2'b11));
        step();
        check("R4", "done one cycle", {31'b0, done}, 32'd0);
        tread(1'b1, 7'd5, 3'd4);
        check("R3", "data word 4", dat_q, WB);
        // boundary sets and word indices
        twrite(1'b0, 1'b0, 7'd127, 3'd7, WC, tw(24'h000127, 1'b0, 2'b10));
        twrite(1'b0, 1'b0, 7'd0, 3'd0, WD, tw(24'hFFFFFF, 1'b0, 2'b01));
        tread(1'b0, 7'd127, 3'd7);
        check("R2", "set 127 word 7 data", dat_q, WC);
        check("R2", "set 127 tag", tag_q, tw(24'h000127, 1'b0, 2'b10));
        tread(1'b0, 7'd0, 3'd0);
        check("R2", "set 0 word 0 data", dat_q, WD);
        check("R2", "set 0 tag", tag_q, tw(24'hFFFFFF, 1'b0, 2'b01));
    endtask

    task automatic test_lookup();
        look(1'b1, 7'd5, 24'hABCDE1);
        check("R8", "hit", {31'b0, hit}, 32'd1);
        check("R8", "hit_way", {31'b0, hit_way}, 32'd1);
        check("R3", "writeback attribute", {31'b0, hit_wb}, 32'd1);
        look(1'b1, 7'd5, 24'hABCDE0);
        check("R8", "wrong tag misses", {31'b0, hit}, 32'd0);
        look(1'b0, 7'd5, 24'hABCDE1);
        check("R8", "invalid request misses", {31'b0, hit}, 32'd0);
        look(1'b1, 7'd127, 24'h000127);
        check("R10", "Exclusive hits", {30'b0, hit, hit_way}, 32'd2);
        check("R3", "writethrough attribute", {31'b0, hit_wb}, 32'd0);
        look(1'b1, 7'd0, 24'hFFFFFF);
        check("R10", "Shared hits", {31'b0, hit}, 32'd1);
    endtask

    task automatic test_states();
        twrite(1'b1, 1'b0, 7'd9, 3'd0, 32'h1, tw(24'h0C0FFE, 1'b0, 2'b11));
        look(1'b1, 7'd9, 24'h0C0FFE);
        check("R10", "Modified hits", {29'b0, hit, hit_way, hit_wb}, 32'b101);
        twrite(1'b1, 1'b0, 7'd9, 3'd0, 32'h1, tw(24'h0C0FFE, 1'b0, 2'b00));
        look(1'b1, 7'd9, 24'h0C0FFE);
        check("R10", "Invalid misses", {29'b0, hit, hit_way, hit_wb}, 32'b000);
    endtask

    task automatic test_both_ways();
        twrite(1'b0, 1'b0, 7'd20, 3'd0, 32'h2, tw(24'h777777, 1'b0, 2'b01));
        twrite(1'b1, 1'b1, 7'd20, 3'd0, 32'h3, tw(24'h777777, 1'b0, 2'b11));
        look(1'b1, 7'd20, 24'h777777);
        check("R9", "way 0 priority", {29'b0, hit, hit_way, hit_wb}, 32'b100);
    endtask

    task automatic test_normal_op();
        load_regs(32'hFFFF_0000, tw(24'h111111, 1'b0, 2'b00));
        issue(cw(1'b0, 1'b1, 7'd5, 3'd3, 2'b00));
        check("R2", "no done on no-op", {31'b0, done}, 32'd0);
        check("R2", "no-op keeps dat_q", dat_q, 32'hFFFF_0000);
        tread(1'b1, 7'd5, 3'd3);
        check("R2", "no-op left data", dat_q, WA);
        check("R2", "no-op left tag", tag_q, tw(24'hABCDE1, 1'b1, 2'b11));
    endtask

    task automatic test_read_priority();
        load_regs(32'd0, 32'd0);
        dat_we = 1'b1; dat_wdata = 32'h1234_5678;
        ctl_we = 1'b1; ctl_word = cw(1'b0, 1'b1, 7'd5, 3'd4, 2'b10);
        step();
        dat_we = 1'b0; ctl_we = 1'b0;
        check("R11", "read beats host write", dat_q, WB);
    endtask

    task automatic test_flush();
        busy_cycles = 0;
        issue(cw(1'b0, 1'b0, 7'd0, 3'd0, 2'b11));
        check("R6", "busy after flush", {31'b0, busy}, 32'd1);
        load_regs(32'hC0C0_C0C0, tw(24'hABCDE1, 1'b0, 2'b11));
        issue(cw(1'b1, 1'b1, 7'd5, 3'd3, 2'b01));
        issue(cw(1'b0, 1'b1, 7'd5, 3'd3, 2'b10));
        check("R7", "no done while busy", {31'b0, done}, 32'd0);
        check("R7", "read ignored while busy", dat_q, 32'hC0C0_C0C0);
        while (busy) step();
        step();
        check("R6", "busy length", busy_cycles, 32'd128);
        look(1'b1, 7'd5, 24'hABCDE1);
        check("R6", "set 5 invalid", {31'b0, hit}, 32'd0);
        look(1'b1, 7'd127, 24'h000127);
        check("R6", "set 127 invalid", {31'b0, hit}, 32'd0);
        look(1'b1, 7'd20, 24'h777777);
        check("R6", "set 20 invalid", {31'b0, hit}, 32'd0);
        tread(1'b1, 7'd5, 3'd3);
        check("R7", "ignored write left data", dat_q, WA);
        check("R6", "tag and pointer kept", tag_q, tw(24'hABCDE1, 1'b1, 2'b00));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    endtask

    initial begin
        #1000000;
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        ctl_we = 1'b0; ctl_word = '0;
        dat_we = 1'b0; dat_wdata = '0;
        tag_we = 1'b0; tag_wdata = '0;
        lk_valid = 1'b0; lk_set = '0; lk_tag = '0;
        repeat (3) step();
        rst = 1'b0;
        test_reset();
        test_host_regs();
        test_write_read();
        test_lookup();
        test_states();
        test_both_ways();
        test_normal_op();
        test_read_priority();
        test_flush();
        summary();
        $finish;
    end

endmodule